// File: doc/BRIEF.md
# ALU Operation Control Decoder

This block chooses the function the ALU performs for each instruction of a 64-bit load/store register machine. The main control unit hands it a 2-bit operation class. The instruction supplies its 11-bit opcode field. From these two inputs the block produces a 4-bit ALU function code.

Memory-access instructions need an address sum, so their class forces addition. The compare-and-branch-if-zero class forces the ALU to pass its second operand through unchanged. The ALU zero flag then shows directly whether that register holds zero, with no subtraction involved. Register-format instructions take their function from a full-width match on the opcode.

The unused class, and any opcode that is not recognised under the register-format class, fall back to addition and raise a flag. The block is purely combinational and has no clock or reset.

Top module: `alu_op_ctl`

## Requirements
- R1: With class 2'b00, the function output is addition (4'b0010) and the illegal flag is 0, whatever the opcode.
- R2: With class 2'b01, the function output is pass-operand-b (4'b0111) and the illegal flag is 0, whatever the opcode.
- R3: With class 2'b10 and opcode 11'b10001011000, the output is addition (4'b0010) and the flag is 0.
- R4: With class 2'b10 and opcode 11'b11001011000, the output is subtraction (4'b0110) and the flag is 0.
- R5: With class 2'b10 and opcode 11'b10001010000, the output is bitwise AND (4'b0000) and the flag is 0.
- R6: With class 2'b10 and opcode 11'b10101010000, the output is bitwise OR (4'b0001) and the flag is 0.
- R7: With class 2'b10 and opcode 11'b11001010000, the output is bitwise XOR (4'b1100) and the flag is 0.
- R8: With class 2'b10, every other opcode gives addition (4'b0010) with the illegal flag at 1. This includes an opcode that differs from a supported one in a single bit, because matching uses all 11 bits.
- R9: With class 2'b11, the output is addition (4'b0010) and the illegal flag is 1, whatever the opcode.
- R10: The outputs follow changes on the inputs with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main control unit |
| opcode | input | 11 | Opcode field of the current instruction |
| alu_fn | output | 4 | Function code for the ALU |
| op_illegal | output | 1 | High when the class/opcode pair is not supported |

## Verification
The bench builds the block with its default widths: an 11-bit opcode and a 4-bit function code. These are the widths at which the five supported opcodes are defined.

At these widths, every single-bit neighbour of each supported opcode can be tried under the register-format class. Some of these neighbours are themselves supported opcodes, for example the add and subtract codes differ in one bit. The bench therefore confirms that a partial decode neither aliases one operation onto another nor lets a near miss through. It also sweeps a set of opcodes under every class, to show that the classes other than register-format ignore the opcode.

// File: rtl/alu_op_ctl_pkg.sv
// Package: shared widths, class and function encodings, and the table of
// register-format opcodes for the ALU operation control decoder.
// Assumes opcode matching is always done on the full opcode field.
package alu_op_ctl_pkg;

    localparam int OPC_W    = 11;
    localparam int FN_W     = 4;
    localparam int CLS_W    = 2;
    localparam int NUM_RFMT = 5;

    typedef enum logic [CLS_W-1:0] {
        CLS_MEM   = 2'b00,
        CLS_ZTEST = 2'b01,
        CLS_RFMT  = 2'b10,
        CLS_RSVD  = 2'b11
    } op_class_e;

    typedef enum logic [FN_W-1:0] {
        FN_AND   = 4'b0000,
        FN_OR    = 4'b0001,
        FN_ADD   = 4'b0010,
        FN_SUB   = 4'b0110,
        FN_PASSB = 4'b0111,
        FN_XOR   = 4'b1100
    } alu_fn_e;

    // Opcode of register-format entry i.
    function automatic logic [OPC_W-1:0] rfmt_opc(input int i);
        case (i)
            0:       rfmt_opc = 11'b10001011000;
            1:       rfmt_opc = 11'b11001011000;
            2:       rfmt_opc = 11'b10001010000;
            3:       rfmt_opc = 11'b10101010000;
            default: rfmt_opc = 11'b11001010000;
        endcase
    endfunction

    // ALU function of register-format entry i.
    function automatic alu_fn_e rfmt_fn(input int i);
        case (i)
            0:       rfmt_fn = FN_ADD;
            1:       rfmt_fn = FN_SUB;
            2:       rfmt_fn = FN_AND;
            3:       rfmt_fn = FN_OR;
            default: rfmt_fn = FN_XOR;
        endcase
    endfunction

endpackage

// File: rtl/alu_rfmt_decode.sv
// Register-format opcode decoder.
// Compares the opcode against every table entry in parallel and returns the
// matching function together with a hit flag.
// Assumes the table entries are distinct, so at most one entry matches.
module alu_rfmt_decode
    import alu_op_ctl_pkg::*;
#(
    parameter int OPC_BITS = OPC_W,
    parameter int N_OPS    = NUM_RFMT
) (
    input  logic [OPC_BITS-1:0] opcode,
    output logic [N_OPS-1:0]    hit,
    output alu_fn_e             dec_fn,
    output logic                dec_known
);

    // One full-width comparator per table entry.
    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cmp
        assign hit[gi] = (opcode == OPC_BITS'(rfmt_opc(gi)));
    end

    // Pick the function of whichever entry hit; addition when none did.
    always_comb begin
        dec_fn    = FN_ADD;
        dec_known = 1'b0;
        for (int i = 0; i < N_OPS; i++) begin
            if (hit[i]) begin
                dec_fn    = rfmt_fn(i);
                dec_known = 1'b1;
            end
        end
    end

    // Table entries never overlap, so at most one comparator may fire (R8).
    always_comb begin
        // R8
        hit_onehot_chk: assert ($onehot0(hit))
            else $error("more than one opcode entry matched");
    end

endmodule

// File: rtl/alu_class_select.sv
// Class selector.
// Turns the operation class into the final ALU function and illegal flag.
// Under the register-format class it takes the decoder's result; the other
// classes override it.
// Assumes the decoder reports addition when it finds no match.
module alu_class_select
    import alu_op_ctl_pkg::*;
(
    input  logic [CLS_W-1:0] op_class,
    input  alu_fn_e          dec_fn,
    input  logic             dec_known,
    output alu_fn_e          sel_fn,
    output logic             sel_illegal
);

    // Choose the ALU function according to the operation class.
    always_comb begin
        sel_fn      = FN_ADD;
        sel_illegal = 1'b0;
        case (op_class_e'(op_class))
            CLS_MEM:   sel_fn = FN_ADD;
            CLS_ZTEST: sel_fn = FN_PASSB;
            CLS_RFMT: begin
                sel_fn      = dec_fn;
                sel_illegal = !dec_known;
            end
            default: begin
                sel_fn      = FN_ADD;
                sel_illegal = 1'b1;
            end
        endcase
    end

    // Cross-check the class overrides against the selected outputs.
    always_comb begin
        // R1
        mem_class_add_chk: assert (op_class != 2'b00 || (sel_fn == FN_ADD && !sel_illegal))
            else $error("memory class did not force addition");
        // R2
        ztest_class_passb_chk: assert (op_class != 2'b01 || (sel_fn == FN_PASSB && !sel_illegal))
            else $error("zero-test class did not force pass-b");
        // R9
        rsvd_class_flag_chk: assert (op_class != 2'b11 || (sel_fn == FN_ADD && sel_illegal))
            else $error("reserved class not flagged");
        // R8
        illegal_add_chk: assert (!sel_illegal || sel_fn == FN_ADD)
            else $error("illegal flag raised with non-add function");
    end

endmodule

// File: rtl/alu_op_ctl.sv
// ALU operation control decoder, top level.
// Combines the operation class from the main control unit with the
// instruction opcode and produces the 4-bit ALU function code plus a flag
// for unsupported combinations.
// Purely combinational; the surrounding datapath registers the result if it
// needs to.
module alu_op_ctl
    import alu_op_ctl_pkg::*;
(
    input  logic [1:0]  op_class,
    input  logic [10:0] opcode,
    output logic [3:0]  alu_fn,
    output logic        op_illegal
);

    localparam int N_OPS = NUM_RFMT;

    logic [N_OPS-1:0] hit;
    alu_fn_e          dec_fn;
    logic             dec_known;
    alu_fn_e          sel_fn;
    logic             sel_illegal;

    alu_rfmt_decode #(
        .OPC_BITS (OPC_W),
        .N_OPS    (N_OPS)
    ) u_dec (
        .opcode    (opcode),
        .hit       (hit),
        .dec_fn    (dec_fn),
        .dec_known (dec_known)
    );

    alu_class_select u_sel (
        .op_class    (op_class),
        .dec_fn      (dec_fn),
        .dec_known   (dec_known),
        .sel_fn      (sel_fn),
        .sel_illegal (sel_illegal)
    );

    // Drive the ports from the selector.
    always_comb begin
        alu_fn     = sel_fn;
        op_illegal = sel_illegal;
    end

    // A decoder hit under the register-format class is never flagged (R3).
    always_comb begin
        // R3
        rfmt_hit_legal_chk: assert (!(op_class == 2'b10 && |hit) || !op_illegal)
            else $error("recognised opcode flagged illegal");
    end

endmodule

// File: tb/alu_op_ctl_test.sv
// Scoreboard bench for alu_op_ctl.
// The driver applies inputs on the falling edge and queues the expected
// outputs. The monitor checks them on the following rising edge.
module alu_op_ctl_test;

    typedef struct {
        logic [1:0]  cls;
        logic [10:0] opc;
        logic [3:0]  fn;
        logic        ill;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_class = 2'b00;
    logic [10:0] opcode = '0;
    logic [3:0]  alu_fn;
    logic        op_illegal;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    alu_op_ctl uut (
        .op_class   (op_class),
        .opcode     (opcode),
        .alu_fn     (alu_fn),
        .op_illegal (op_illegal)
    );

    // Expected outputs, written from the requirements.
    function automatic void model(input logic [1:0] c, input logic [10:0] o,
                                  output logic [3:0] fn, output logic ill);
        fn  = 4'b0010;
        ill = 1'b0;
        case (c)
            2'b00: fn = 4'b0010;
            2'b01: fn = 4'b0111;
            2'b10: begin
                case (o)
                    11'b10001011000: fn = 4'b0010;
                    11'b11001011000: fn = 4'b0110;
                    11'b10001010000: fn = 4'b0000;
                    11'b10101010000: fn = 4'b0001;
                    11'b11001010000: fn = 4'b1100;
                    default:         ill = 1'b1;
                endcase
            end
            default: ill = 1'b1;
        endcase
    endfunction

    task automatic drive(input logic [1:0] c, input logic [10:0] o, input string tag);
        item_t it;
        @(negedge clk);
        op_class = c;
        opcode   = o;
        it.cls = c;
        it.opc = o;
        it.tag = tag;
        model(c, o, it.fn, it.ill);
        sb_q.push_back(it);
    endtask

    // Monitor: compare one queued item per rising edge.
    always @(posedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (alu_fn !== it.fn || op_illegal !== it.ill) begin
                errors++;
                $display("FAIL %s: class=%b opcode=%b got fn=%b ill=%b expected fn=%b ill=%b",
                         it.tag, it.cls, it.opc, alu_fn, op_illegal, it.fn, it.ill);
            end
        end
    end

    localparam logic [10:0] SUPPORTED [5] = '{11'b10001011000, 11'b11001011000,
        11'b10001010000, 11'b10101010000, 11'b11001010000};

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // Settled state straight after the bench reset: class 00, opcode 0.
        drive(2'b00, 11'd0, "R1 initial");
        drive(2'b00, 11'b10001011000, "R1");
        drive(2'b00, 11'h7FF, "R1");
        drive(2'b00, 11'b11001011000, "R1");
        drive(2'b01, 11'd0, "R2");
        drive(2'b01, 11'h7FF, "R2");
        drive(2'b01, 11'b11001010000, "R2");
        drive(2'b10, 11'b10001011000, "R3");
        drive(2'b10, 11'b11001011000, "R4");
        drive(2'b10, 11'b10001010000, "R5");
        drive(2'b10, 11'b10101010000, "R6");
        drive(2'b10, 11'b11001010000, "R7");
        drive(2'b10, 11'd0, "R8");
        drive(2'b10, 11'h7FF, "R8");
        // Single-bit neighbours of each supported opcode (R8).
        for (int s = 0; s < 5; s++) begin
            for (int b = 0; b < 11; b++) begin
                drive(2'b10, SUPPORTED[s] ^ (11'd1 << b), "R8 neighbour");
            end
        end
        drive(2'b11, 11'b10001011000, "R9");
        drive(2'b11, 11'd0, "R9");
        drive(2'b11, 11'b11001010000, "R9");
        // Every class against every supported opcode.
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 5; s++) begin
                drive(2'(c), SUPPORTED[s], "R1 R2 R9 sweep");
            end
        end
        // R10: outputs follow an input change with no clock edge in between.
        @(negedge clk);
        op_class = 2'b10;
        opcode   = 11'b11001011000;
        #1;
        checks++;
        if (alu_fn !== 4'b0110 || op_illegal !== 1'b0) begin
            errors++;
            $display("FAIL R10: got fn=%b ill=%b expected fn=0110 ill=0", alu_fn, op_illegal);
        end
        op_class = 2'b01;
        #1;
        checks++;
        if (alu_fn !== 4'b0111 || op_illegal !== 1'b0) begin
            errors++;
            $display("FAIL R10: got fn=%b ill=%b expected fn=0111 ill=0", alu_fn, op_illegal);
        end
        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule